// File: doc/BRIEF.md
# Multiplexed-Address Byte Memory

A storage array of 128 bytes built entirely from flip-flops and arranged in the two-and-a-half-dimensional style: sixteen rows, each eight bytes wide. To keep the pin count low, the address does not arrive all at once. It comes over four shared pins in two steps. A row strobe loads the row part of the address. A column strobe then loads the column part. Once both parts have been loaded, the stored byte at that location appears on the data output, and a write-enable pulse replaces it.

A one-hot row decoder (4-to-16) picks a row. Rows share a wired-OR bit bus, so no row multiplexer is needed. Eight 8-to-1 column multiplexers, one per data bit, pick the byte from that bus. On a write, a 3-to-8 column enable decoder is ANDed with the row select, so exactly one byte is enabled. No decoder is larger than 4-to-16 and no multiplexer is larger than 8-to-1.

Top module: `mbm_byte_array`

## Requirements
- R1: Synchronous active-high reset marks both address latches as empty. While either latch is empty, `rd_data` reads 0. Reset does not clear the stored bytes.
- R2: The array holds 128 independent 8-bit words. Each location returns the last byte written to it, without disturbance from writes to other locations.
- R3: On a clock edge with `row_stb` high, `adr_pins[3:0]` is captured as address bits [6:3]. The row latch keeps its value on every other edge.
- R4: On a clock edge with `col_stb` high, `adr_pins[2:0]` is captured as address bits [2:0]. `adr_pins[3]` is ignored during a column strobe.
- R5: Bit 7 of an 8-bit address has no pin, so addresses that differ only in bit 7 reach the same byte. Loading a new row while the column latch is held reads the byte at the new row and the old column.
- R6: A write takes place on a clock edge with `wr_en` high and both latches loaded. It changes only the byte at the latched row and column. A `wr_en` pulse given while either latch is empty changes no byte.
- R7: `rd_data` is combinational from the latched address and the array. It shows the selected byte right after the edge that loads the second latch, with no extra strobe.
- R8: A write on the same edge as a strobe uses the address held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adr_pins | input | 4 | Shared address pins: row bits [6:3], or column bits [2:0] on the low three pins |
| row_stb | input | 1 | Load the row latch from the pins |
| col_stb | input | 1 | Load the column latch from the pins |
| wr_en | input | 1 | Write the latched byte on this edge |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte at the latched address, or 0 while a latch is empty |

## Verification
The array is first filled with random bytes through 8-bit addresses with a random bit 7. It is then read back in full, which separates correct row/column decoding from aliased or stray writes (R2, R5). Random reads and writes are mixed, each with a random value on the unused pin during the column strobe, to show that pin 3 never reaches the column (R4). Directed cases cover the following:
- an output of zero after reset, and with only the row loaded;
- `wr_en` pulses with no latch loaded, and with only the row loaded, which must leave the target byte intact;
- a row re-strobe with the column held, which shows that the two latches are independent;
- a write given together with a column strobe, which separates old-address from new-address writes.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  localparam int unsigned MBM_DATA_W = 8;
  localparam int unsigned MBM_ROW_W  = 4;
  localparam int unsigned MBM_COL_W  = 3;

  function automatic int unsigned mbm_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mbm_addr_latch.sv
module mbm_addr_latch #(
  parameter int unsigned ROW_W = 4,
  parameter int unsigned COL_W = 3,
  parameter int unsigned PIN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             row_stb_i,
  input  logic             col_stb_i,
  input  logic [PIN_W-1:0] pins_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             row_vld_o,
  output logic             col_vld_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_o     <= '0;
      col_o     <= '0;
      row_vld_o <= 1'b0;
      col_vld_o <= 1'b0;
    end else begin
      if (row_stb_i) begin
        row_o     <= pins_i[ROW_W-1:0];
        row_vld_o <= 1'b1;
      end
      if (col_stb_i) begin
        col_o     <= pins_i[COL_W-1:0];
        col_vld_o <= 1'b1;
      end
    end
  end

  AST_ROW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    row_stb_i |=> (row_o == $past(pins_i[ROW_W-1:0]))); // R3
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !row_stb_i |=> $stable(row_o)); // R3
  AST_COL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    col_stb_i |=> (col_o == $past(pins_i[COL_W-1:0]))); // R4
  AST_RESET_EMPTY: assert property (@(posedge clk)
    $past(rst) |-> (!row_vld_o && !col_vld_o)); // R1

endmodule

// File: rtl/mbm_onehot_dec.sv
module mbm_onehot_dec #(
  parameter int unsigned IN_W = 4,
  localparam int unsigned OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  sel_i,
  input  logic             en_i,
  output logic [OUT_N-1:0] dec_o
);

  for (genvar k = 0; k < OUT_N; k++) begin : g_line
    assign dec_o[k] = en_i && (sel_i == IN_W'(k));
  end

endmodule

// File: rtl/mbm_col_mux.sv
module mbm_col_mux #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COL_W  = 3,
  localparam int unsigned COLS  = 1 << COL_W
) (
  input  logic [COLS*DATA_W-1:0] row_bus_i,
  input  logic [COL_W-1:0]       col_i,
  output logic [DATA_W-1:0]      byte_o
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic [COLS-1:0] lane;
    for (genvar c = 0; c < COLS; c++) begin : g_lane
      assign lane[c] = row_bus_i[c*DATA_W + b];
    end
    assign byte_o[b] = lane[col_i];
  end

endmodule

// File: rtl/mbm_byte_array.sv
module mbm_byte_array
  import mbm_pkg::*;
#(
  parameter int unsigned DATA_W = MBM_DATA_W,
  parameter int unsigned ROW_W  = MBM_ROW_W,
  parameter int unsigned COL_W  = MBM_COL_W,
  localparam int unsigned PIN_W = mbm_max(ROW_W, COL_W),
  localparam int unsigned ROWS  = 1 << ROW_W,
  localparam int unsigned COLS  = 1 << COL_W,
  localparam int unsigned ROW_BITS = COLS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIN_W-1:0]  adr_pins,
  input  logic              row_stb,
  input  logic              col_stb,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [ROW_W-1:0]     row_q;
  logic [COL_W-1:0]     col_q;
  logic                 row_vld, col_vld, adr_ok, wr_fire;
  logic [ROWS-1:0]      row_sel;
  logic [COLS-1:0]      col_we;
  logic [ROWS*COLS-1:0] word_we;
  logic [ROW_BITS-1:0]  mem_q [ROWS];
  logic [ROW_BITS-1:0]  bit_bus;
  logic [DATA_W-1:0]    mux_byte;

  mbm_addr_latch #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .row_stb_i (row_stb),
    .col_stb_i (col_stb),
    .pins_i    (adr_pins),
    .row_o     (row_q),
    .col_o     (col_q),
    .row_vld_o (row_vld),
    .col_vld_o (col_vld)
  );

  assign adr_ok  = row_vld && col_vld;
  assign wr_fire = wr_en && adr_ok;

  mbm_onehot_dec #(.IN_W(ROW_W)) u_row_dec (
    .sel_i (row_q),
    .en_i  (1'b1),
    .dec_o (row_sel)
  );

  mbm_onehot_dec #(.IN_W(COL_W)) u_col_dec (
    .sel_i (col_q),
    .en_i  (wr_fire),
    .dec_o (col_we)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_word
      assign word_we[r*COLS + c] = row_sel[r] && col_we[c];
      always_ff @(posedge clk) begin
        if (word_we[r*COLS + c]) mem_q[r][c*DATA_W +: DATA_W] <= wr_data;
      end
    end
  end

  always_comb begin
    bit_bus = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (row_sel[r]) bit_bus = bit_bus | mem_q[r];
    end
  end

  mbm_col_mux #(.DATA_W(DATA_W), .COL_W(COL_W)) u_col_mux (
    .row_bus_i (bit_bus),
    .col_i     (col_q),
    .byte_o    (mux_byte)
  );

  assign rd_data = adr_ok ? mux_byte : '0;

  AST_ONE_WORD_WRITE: assert property (@(posedge clk) disable iff (rst)
    $countones(word_we) == (wr_fire ? 1 : 0)); // R6
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (mem_q[$past(row_q)][$past(col_q)*DATA_W +: DATA_W] == $past(wr_data))); // R8
  AST_ROW_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel) && (row_sel != '0)); // R2

endmodule

// File: tb/mbm_byte_array_tb.sv
module mbm_byte_array_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] adr_pins = '0;
  logic       row_stb = 1'b0, col_stb = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_mem [128];

  always #5 clk = ~clk;

  mbm_byte_array u_dut (
    .clk(clk), .rst(rst), .adr_pins(adr_pins), .row_stb(row_stb),
    .col_stb(col_stb), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic int idx_of(input logic [7:0] a);
    return int'(a[6:0]);
  endfunction

  function automatic logic [7:0] expect_at(input logic [7:0] a);
    return exp_mem[idx_of(a)];
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic load_row(input logic [7:0] a);
    @(negedge clk); row_stb = 1'b1; adr_pins = a[6:3];
    @(negedge clk); row_stb = 1'b0; adr_pins = 4'($urandom);
  endtask

  task automatic load_col(input logic [7:0] a, input logic p3);
    @(negedge clk); col_stb = 1'b1; adr_pins = {p3, a[2:0]};
    @(negedge clk); col_stb = 1'b0; adr_pins = 4'($urandom);
  endtask

  task automatic set_addr(input logic [7:0] a);
    load_row(a);
    load_col(a, 1'($urandom));
  endtask

  task automatic write_byte(input logic [7:0] a, input logic [7:0] d);
    set_addr(a);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'($urandom);
    exp_mem[idx_of(a)] = d;
  endtask

  task automatic read_check(input logic [7:0] a, input string req);
    set_addr(a);
    #1 check(req, rd_data, expect_at(a));
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0101));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 check("R1 reset output", rd_data, 8'h00);
    load_row(8'h35);
    #1 check("R1 row only output", rd_data, 8'h00);

    // Fill the whole array, bit 7 random
    for (int a = 0; a < 128; a++)
      write_byte({1'($urandom), 7'(a)}, 8'($urandom));
    for (int a = 0; a < 128; a++)
      read_check({1'($urandom), 7'(a)}, "R2 R5 full readback");

    // R4: pin 3 ignored on column strobe
    load_row(8'h5A);
    load_col(8'h5A, 1'b1);
    #1 check("R4 pin3 high", rd_data, expect_at(8'h5A));
    load_col(8'h5A, 1'b0);
    #1 check("R4 pin3 low", rd_data, expect_at(8'h5A));

    // R5: new row, column held
    set_addr(8'h13);
    load_row(8'h6B);
    #1 check("R5 row restrobe", rd_data, expect_at(8'h6B));

    // R7: column change alone updates output right after the strobe edge
    load_col(8'h6E, 1'b0);
    #1 check("R7 column only", rd_data, expect_at(8'h6E));

    // R8: write together with a column strobe uses the held address
    set_addr(8'h21);
    @(negedge clk); col_stb = 1'b1; adr_pins = 4'h6; wr_en = 1'b1; wr_data = 8'hC3;
    @(negedge clk); col_stb = 1'b0; wr_en = 1'b0;
    exp_mem[8'h21] = 8'hC3;
    #1 check("R8 new column output", rd_data, expect_at(8'h26));
    read_check(8'h21, "R8 old address written");
    read_check(8'h26, "R8 new address untouched");

    // R6 and R1: write pulses with latches empty, memory kept over reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk); wr_en = 1'b1; wr_data = ~exp_mem[0];
    @(negedge clk); wr_en = 1'b0;
    load_row(8'h48);
    @(negedge clk); wr_en = 1'b1; wr_data = ~exp_mem[8'h48];
    @(negedge clk); wr_en = 1'b0;
    #1 check("R6 row only no output", rd_data, 8'h00);
    read_check(8'h48, "R6 unarmed write ignored");
    read_check(8'h00, "R1 R6 kept over reset");

    // R6: a write touches only its byte
    write_byte(8'h3C, 8'hA5);
    read_check(8'h3C, "R6 target written");
    read_check(8'h3D, "R6 neighbour column");
    read_check(8'h44, "R6 neighbour row");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic [7:0] a;
      a = 8'($urandom);
      if ($urandom_range(1, 0) == 1) write_byte(a, 8'($urandom));
      else read_check(a, "R2 R3 R4 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule